// File: doc/BRIEF.md
# Transmit Buffer Status Flag Register

This block keeps the status of three transmit message buffers for a message controller. For each buffer it holds an empty flag and an abort-acknowledge flag, which the CPU reads from one 8-bit register. It also holds an abort-request bit and an interrupt-enable bit for each buffer. The CPU hands a loaded buffer to the transmit engine by writing 1 to that buffer's empty flag, which clears it. The engine then sees the buffer as pending. When the engine finishes, it reports a successful send or a successful abort. The block marks the buffer empty again, records which of the two outcomes happened, and retracts any abort request for that buffer.

A combined interrupt line is high while any empty buffer has its interrupt enabled. An asynchronous hard reset returns every bit to its reset value. A level-sensitive soft-reset input holds the flags and the abort requests in their reset state for as long as it is high. The interrupt enables are not affected by the soft reset.

Top module: `txbuf_flag_regs`

## Requirements
- R1: The status read word has the abort-acknowledge flags of buffers 2..0 in bits 6..4 and the empty flags of buffers 2..0 in bits 2..0. Bits 7 and 3 always read 0.
- R2: After hard reset the status reads 0x07. All abort requests and interrupt enables are 0, and irq is 0.
- R3: Writing the status register with a 1 in bit x (x = 0..2) clears empty flag x. A 0 in that bit leaves the flag unchanged.
- R4: Bits 6..4 of a status write have no effect. The abort-acknowledge flags are never set by a CPU write.
- R5: When empty flag x is cleared, abort-acknowledge flag x becomes 0 on the same clock.
- R6: A sent_ok pulse for buffer x sets empty flag x and leaves abort-acknowledge flag x at 0.
- R7: An abort_done pulse for buffer x sets empty flag x and sets abort-acknowledge flag x. If sent_ok and abort_done arrive together, abort_done decides the acknowledge value.
- R8: On any clock where empty flag x becomes set, abort request x becomes 0.
- R9: irq is high exactly while some buffer x has empty flag 1 and interrupt enable 1. An enable write loads all three enables from ien_wdata.
- R10: While soft_rst is 1, the status reads 0x07 and all abort requests are 0. The interrupt enables keep their values.
- R11: An abort write with a 1 in bit x sets abort request x only if empty flag x is 0 and no engine event for x arrives on that clock. A 0 in bit x has no effect.
- R12: pending[x] is always the inverse of empty flag x.
- R13: If a CPU clear and an engine event for the same buffer occur on the same clock, the empty flag ends up 1. The abort-acknowledge flag then takes the value the engine event gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Soft reset level; holds flags and abort requests at reset values |
| stat_wr | input | 1 | Write strobe for the status register |
| stat_wdata | input | 8 | Status write data; 1 in bits 2..0 clears empty flags |
| abrt_wr | input | 1 | Write strobe for abort requests |
| abrt_wdata | input | 3 | 1 in bit x requests an abort of buffer x |
| ien_wr | input | 1 | Write strobe for interrupt enables |
| ien_wdata | input | 3 | New interrupt enable values |
| sent_ok | input | 3 | Engine pulse: buffer x sent successfully |
| abort_done | input | 3 | Engine pulse: buffer x aborted successfully |
| stat_rdata | output | 8 | Status read word |
| abort_req | output | 3 | Abort request bits, one per buffer |
| pending | output | 3 | Buffer x is scheduled for transmission |
| irq | output | 1 | Combined transmit interrupt |

## Verification
Directed sequences run the full buffer life cycle: load, send, abort request, abort. These separate the sent outcome from the aborted outcome in the acknowledge flags, and show the abort request being retracted. Writes with 0 bits, writes to the read-only field, and abort requests made while a buffer is empty show whether the block ignores what it must ignore. Same-clock collisions of a CPU clear with an engine event, and of a send with an abort, confirm the precedence rules. A long run of mixed random stimulus, including soft-reset pulses and enable changes, is compared every clock against a behavioural model. This exposes cross-buffer leakage and any wrong priority between concurrent events.

// File: rtl/txbuf_flag_pkg.sv
package txbuf_flag_pkg;
    localparam int NBUF    = 3;
    localparam int REG_W   = 8;
    localparam int TXE_LSB = 0;
    localparam int ABK_LSB = 4;

    typedef struct packed {
        logic txe;
        logic abk;
        logic arq;
        logic ien;
    } buf_state_t;
endpackage

// File: rtl/txbuf_flag_slice.sv
module txbuf_flag_slice
    import txbuf_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic clr_i,
    input  logic arq_set_i,
    input  logic ien_wr_i,
    input  logic ien_bit_i,
    input  logic sent_i,
    input  logic abort_i,
    output logic txe_o,
    output logic abk_o,
    output logic arq_o,
    output logic ien_o
);
    buf_state_t st_d, st_q;
    logic evt;

    always_comb begin
        st_d = st_q;
        evt  = sent_i | abort_i;
        if (ien_wr_i) st_d.ien = ien_bit_i;
        if (soft_rst_i) begin
            st_d.txe = 1'b1;
            st_d.abk = 1'b0;
            st_d.arq = 1'b0;
        end else if (evt) begin
            st_d.txe = 1'b1;
            st_d.abk = abort_i;
            st_d.arq = 1'b0;
        end else begin
            if (clr_i && st_q.txe) begin
                st_d.txe = 1'b0;
                st_d.abk = 1'b0;
            end
            if (arq_set_i && !st_q.txe) st_d.arq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{txe: 1'b1, abk: 1'b0, arq: 1'b0, ien: 1'b0};
        else        st_q <= st_d;
    end

    assign txe_o = st_q.txe;
    assign abk_o = st_q.abk;
    assign arq_o = st_q.arq;
    assign ien_o = st_q.ien;

    // R3
    clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.txe) |-> $past(clr_i));
    // R4
    abk_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.abk) |-> $past(abort_i));
    // R5
    abk_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.txe) |-> !st_q.abk);
    // R8
    arq_retract_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.txe) |-> !st_q.arq);
    // R11
    arq_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.arq) |-> $past(!st_q.txe && arq_set_i));
endmodule

// File: rtl/txbuf_flag_pack.sv
module txbuf_flag_pack
    import txbuf_flag_pkg::*;
(
    input  logic [NBUF-1:0]  txe_i,
    input  logic [NBUF-1:0]  abk_i,
    input  logic [NBUF-1:0]  ien_i,
    output logic [REG_W-1:0] rdata_o,
    output logic [NBUF-1:0]  pending_o,
    output logic             irq_o
);
    always_comb begin
        rdata_o = '0;
        rdata_o[TXE_LSB +: NBUF] = txe_i;
        rdata_o[ABK_LSB +: NBUF] = abk_i;
    end

    assign pending_o = ~txe_i;
    assign irq_o     = |(txe_i & ien_i);

    // R1
    always_comb begin
        unused_bits_chk: assert (rdata_o[7] == 1'b0 && rdata_o[3] == 1'b0);
    end
endmodule

// File: rtl/txbuf_flag_regs.sv
module txbuf_flag_regs
    import txbuf_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             stat_wr,
    input  logic [REG_W-1:0] stat_wdata,
    input  logic             abrt_wr,
    input  logic [NBUF-1:0]  abrt_wdata,
    input  logic             ien_wr,
    input  logic [NBUF-1:0]  ien_wdata,
    input  logic [NBUF-1:0]  sent_ok,
    input  logic [NBUF-1:0]  abort_done,
    output logic [REG_W-1:0] stat_rdata,
    output logic [NBUF-1:0]  abort_req,
    output logic [NBUF-1:0]  pending,
    output logic             irq
);
    logic [NBUF-1:0] txe, abk, ien;

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        txbuf_flag_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst_i (soft_rst),
            .clr_i      (stat_wr && stat_wdata[TXE_LSB + i]),
            .arq_set_i  (abrt_wr && abrt_wdata[i]),
            .ien_wr_i   (ien_wr),
            .ien_bit_i  (ien_wdata[i]),
            .sent_i     (sent_ok[i]),
            .abort_i    (abort_done[i]),
            .txe_o      (txe[i]),
            .abk_o      (abk[i]),
            .arq_o      (abort_req[i]),
            .ien_o      (ien[i])
        );
    end

    txbuf_flag_pack u_pack (
        .txe_i     (txe),
        .abk_i     (abk),
        .ien_i     (ien),
        .rdata_o   (stat_rdata),
        .pending_o (pending),
        .irq_o     (irq)
    );

    // R12
    pending_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending == ~stat_rdata[TXE_LSB +: NBUF]);
    // R10
    soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (stat_rdata == 8'h07 && abort_req == '0));
endmodule

// File: tb/sim_txbuf_flag_regs.sv
module sim_txbuf_flag_regs;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       stat_wr = 1'b0;
    logic [7:0] stat_wdata = '0;
    logic       abrt_wr = 1'b0;
    logic [2:0] abrt_wdata = '0;
    logic       ien_wr = 1'b0;
    logic [2:0] ien_wdata = '0;
    logic [2:0] sent_ok = '0;
    logic [2:0] abort_done = '0;
    logic [7:0] stat_rdata;
    logic [2:0] abort_req, pending;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int m_txe[3], m_abk[3], m_arq[3], m_ien[3];

    always #(CLK_PERIOD/2) clk = ~clk;

    txbuf_flag_regs u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .abrt_wr(abrt_wr), .abrt_wdata(abrt_wdata),
        .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .sent_ok(sent_ok), .abort_done(abort_done),
        .stat_rdata(stat_rdata), .abort_req(abort_req),
        .pending(pending), .irq(irq)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        int e_rd = 0, e_pend = 0, e_arq = 0, e_irq = 0;
        for (int i = 0; i < 3; i++) begin
            e_rd   |= (m_txe[i] << i) | (m_abk[i] << (4 + i));
            e_pend |= (1 - m_txe[i]) << i;
            e_arq  |= m_arq[i] << i;
            if (m_txe[i] == 1 && m_ien[i] == 1) e_irq = 1;
        end
        chk({tag, " status"}, int'(stat_rdata), e_rd);
        chk("R1 unused bits", int'({stat_rdata[7], stat_rdata[3]}), 0);
        chk("R12 pending", int'(pending), e_pend);
        chk("R11 abort_req", int'(abort_req), e_arq);
        chk("R9 irq", int'(irq), e_irq);
    endtask

    // One clock: compare outputs, drive inputs, advance the model.
    task automatic step(string tag, bit sw, bit [7:0] sd, bit aw, bit [2:0] ad,
                        bit iw, bit [2:0] id, bit [2:0] so, bit [2:0] ab, bit sr);
        @(negedge clk);
        compare(tag);
        stat_wr = sw; stat_wdata = sd; abrt_wr = aw; abrt_wdata = ad;
        ien_wr = iw; ien_wdata = id; sent_ok = so; abort_done = ab; soft_rst = sr;
        for (int i = 0; i < 3; i++) begin
            int ntxe = m_txe[i], nabk = m_abk[i], narq = m_arq[i];
            if (iw) m_ien[i] = id[i];
            if (sr) begin
                ntxe = 1; nabk = 0; narq = 0;
            end else if (so[i] || ab[i]) begin
                ntxe = 1; nabk = ab[i]; narq = 0;
            end else begin
                if (sw && sd[i] && m_txe[i] == 1) begin ntxe = 0; nabk = 0; end
                if (aw && ad[i] && m_txe[i] == 0) narq = 1;
            end
            m_txe[i] = ntxe; m_abk[i] = nabk; m_arq[i] = narq;
        end
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            m_txe[i] = 1; m_abk[i] = 0; m_arq[i] = 0; m_ien[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R2 reset");
        // R3: zero bits ignored, one bits clear
        step("R3 write zero", 1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        step("R3 clear b0", 1, 8'h01, 0, 0, 0, 0, 0, 0, 0);
        // R4: read-only field
        step("R4 ro write", 1, 8'h70, 0, 0, 0, 0, 0, 0, 0);
        idle("R4 after");
        // R11: abort request on empty buffer 1 ignored, on buffer 0 accepted
        step("R11 req", 0, 0, 1, 3'b011, 0, 0, 0, 0, 0);
        idle("R11 after");
        // R7 R8: abort done on buffer 0
        step("R7 abort", 0, 0, 0, 0, 0, 0, 0, 3'b001, 0);
        idle("R7 R8 after");
        // R5: clearing again drops acknowledge
        step("R5 clear", 1, 8'h07, 0, 0, 0, 0, 0, 0, 0);
        idle("R5 after");
        // R6: sent on buffer 2
        step("R6 sent", 0, 0, 0, 0, 0, 0, 3'b100, 0, 0);
        idle("R6 after");
        // R9 enables
        step("R9 ien", 0, 0, 0, 0, 1, 3'b100, 0, 0, 0);
        idle("R9 after");
        step("R9 ien off", 0, 0, 0, 0, 1, 3'b011, 0, 0, 0);
        idle("R9 after2");
        // R13 collision on buffer 2 (empty): clear + abort_done
        step("R13 collide", 1, 8'h04, 0, 0, 0, 0, 0, 3'b100, 0);
        idle("R13 after");
        // R7 both events together
        step("R7 both", 0, 0, 0, 0, 0, 0, 3'b011, 3'b011, 0);
        idle("R7 both after");
        // R10 soft reset hold with enables kept
        step("R10 load", 1, 8'h07, 0, 0, 1, 3'b111, 0, 0, 0);
        step("R10 req", 0, 0, 1, 3'b111, 0, 0, 0, 0, 0);
        step("R10 soft", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R10 soft hold", 1, 8'h07, 1, 3'b111, 0, 0, 0, 0, 1);
        idle("R10 after");
        // mixed random run
        for (int k = 0; k < 2000; k++) begin
            bit [31:0] r = $urandom;
            step("R3 R6 R7 R13 random", r[0], {1'b0, r[3:1], 1'b0, r[6:4]},
                 r[7], r[10:8], r[11] & r[12], r[15:13],
                 r[16] ? r[19:17] : 3'b0, r[20] ? r[23:21] : 3'b0,
                 (r[31:27] == 5'd0));
        end
        idle("final");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule